// File: doc/BRIEF.md
# Register-Pointer I2C Target Front End

This block is the bus side of a register-mapped I/O expander. It oversamples the I2C clock and data lines with the system clock and finds START and STOP conditions. When a transfer starts, it compares the 7-bit address. In a write transfer, the first byte after the address loads a register pointer. Each later byte is written to the register that the pointer selects. In a read transfer, the block fetches bytes from the selected register and shifts them out, most significant bit first.

The block only pulls SDA low: `sda_oe` set to 1 means the pad drives a 0. It acknowledges the address, the command byte and each written byte on the ninth clock. During a read, it keeps sending bytes while the controller acknowledges. After the controller's NACK it stays off the bus until a STOP. The pointer survives a repeated START, so a short write of the command byte followed by a read-direction restart reads from the chosen register. After every data byte, the pointer moves to the other register of its port pair.

The register-bank port carries data both ways but has no back-pressure. Bus timing is fixed and clock stretching is not used, so the bank must accept each one-cycle `reg_wr_en` strobe. It must also present `reg_rdata` for `reg_addr` combinationally, and the block captures that value in the cycle that `reg_rd_en` is high.

Top module: `i2c_regptr_target`

## Requirements
- R1: The target answers only the address formed by the upper nibble 0100 followed by `addr_strap[2:0]`. It answers by holding SDA low through the whole high period of the ninth SCL clock. Bit 0 of the address byte selects the direction: 0 is write, 1 is read.
- R2: On an address mismatch the target gives no acknowledge, writes nothing and leaves SDA released until the next START.
- R3: In a write, the first byte after the address is acknowledged, and its low three bits become the register pointer.
- R4: Each later write byte is acknowledged and produces a single-cycle `reg_wr_en` pulse, with `reg_wdata` equal to the byte and `reg_addr` equal to the pointer.
- R5: After every data byte, written or read, the pointer's bit 0 inverts and its upper bits stay the same. Consecutive bytes therefore alternate between the two registers of a pair.
- R6: In a read, the target sends the register at the pointer, MSB first. It fetches the register with a one-cycle `reg_rd_en` pulse, and this pulse never coincides with `reg_wr_en`.
- R7: If the controller acknowledges a read byte, the target sends the next byte.
- R8: If the controller does not acknowledge, the target releases SDA and ignores everything, including a START, until a STOP. After the STOP it responds normally again.
- R9: A repeated START keeps the pointer, so a write of the command byte followed by a read restart returns that register.
- R10: The SDA drive changes only while SCL is low, and SDA is never driven high.
- R11: After reset, and after every STOP, `sda_oe` is 0 and neither strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Raw SCL line level |
| sda_i | input | 1 | Raw SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| addr_strap | input | 3 | Low three address bits from board straps |
| reg_addr | output | PTR_W | Register pointer to the bank |
| reg_wr_en | output | 1 | One-cycle write strobe |
| reg_wdata | output | 8 | Write data byte |
| reg_rd_en | output | 1 | One-cycle read fetch strobe |
| reg_rdata | input | 8 | Register contents at `reg_addr`, combinational |

## Verification
The hardest state to reach is the one after a controller NACK. There, even a correctly addressed START must be ignored until a STOP arrives. The bench reaches it by ending a read with a NACK and then starting a write to the right address without any STOP in between. It checks that no acknowledge appears and that the register contents do not change. It then issues a STOP and confirms that the target answers again. Randomly generated write and read transfers, with random pointers and byte counts, run between directed cases for the repeated START and the wrong address. A bench-side shadow of the registers and the pointer predicts every byte.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_RACK, ST_WAIT
  } st_e;

  typedef enum logic [1:0] {
    PH_ADDR, PH_CMD, PH_DATA
  } ph_e;
endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
  parameter int STAGES = 2,
  parameter int LINES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] raw_i,
  output logic [LINES-1:0] sync_o
);
  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic [STAGES-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '1;
      else        q <= {q[STAGES-2:0], raw_i[i]};
    end
    assign sync_o[i] = q[STAGES-1];
  end
endmodule

// File: rtl/i2c_tgt_cond.sv
module i2c_tgt_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  assign scl_rise  = !scl_p && scl_s;
  assign scl_fall  = scl_p && !scl_s;
  assign start_det = scl_p && scl_s && sda_p && !sda_s;
  assign stop_det  = scl_p && scl_s && !sda_p && sda_s;
endmodule

// File: rtl/i2c_tgt_ptr.sv
module i2c_tgt_ptr #(
  parameter int PTR_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [PTR_W-1:0] load_val,
  input  logic             step,
  output logic [PTR_W-1:0] ptr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ptr <= '0;
    else if (load) ptr <= load_val;
    else if (step) ptr <= {ptr[PTR_W-1:1], ~ptr[0]};
  end
endmodule

// File: rtl/i2c_regptr_target.sv
module i2c_regptr_target
  import i2c_tgt_pkg::*;
#(
  parameter logic [3:0] ADDR_HI     = 4'b0100,
  parameter int         SYNC_STAGES = 2,
  parameter int         PTR_W       = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe,
  input  logic [2:0]       addr_strap,
  output logic [PTR_W-1:0] reg_addr,
  output logic             reg_wr_en,
  output logic [7:0]       reg_wdata,
  output logic             reg_rd_en,
  input  logic [7:0]       reg_rdata
);
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);

  logic [1:0] raw_l, sync_l;
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  assign raw_l = {sda_i, scl_i};

  i2c_tgt_sync #(.STAGES(SYNC_STAGES), .LINES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw_i(raw_l), .sync_o(sync_l)
  );

  assign scl_s = sync_l[0];
  assign sda_s = sync_l[1];

  i2c_tgt_cond u_cond (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  st_e              st;
  ph_e              ph;
  logic [CNT_W-1:0] cnt;
  logic [7:0]       sr;
  logic [7:0]       tx;
  logic             rw;
  logic             oe_q;
  logic             byte_done, addr_hit, wr_fire, cmd_fire, rd_fire;

  assign byte_done = (cnt == CNT_FULL);
  assign addr_hit  = (sr[7:1] == {ADDR_HI, addr_strap});
  assign wr_fire   = scl_fall && (st == ST_RX) && (ph == PH_DATA) && byte_done;
  assign cmd_fire  = scl_fall && (st == ST_RX) && (ph == PH_CMD) && byte_done;
  assign rd_fire   = scl_fall && (((st == ST_ACK) && (ph == PH_ADDR) && rw) ||
                                  (st == ST_RACK));

  i2c_tgt_ptr #(.PTR_W(PTR_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .load(cmd_fire), .load_val(sr[PTR_W-1:0]),
    .step(wr_fire || rd_fire), .ptr(reg_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      ph   <= PH_ADDR;
      cnt  <= '0;
      sr   <= '0;
      tx   <= '0;
      rw   <= 1'b0;
      oe_q <= 1'b0;
    end else begin
      case (st)
        ST_RX: begin
          if (scl_rise && !byte_done) begin
            sr  <= {sr[6:0], sda_s};
            cnt <= cnt + 1'b1;
          end
          if (scl_fall && byte_done) begin
            if (ph == PH_ADDR) begin
              if (addr_hit) begin
                oe_q <= 1'b1;
                rw   <= sr[0];
                st   <= ST_ACK;
              end else begin
                st <= ST_IDLE;
              end
            end else begin
              oe_q <= 1'b1;
              st   <= ST_ACK;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            cnt <= '0;
            if (ph == PH_ADDR && rw) begin
              tx   <= reg_rdata;
              oe_q <= ~reg_rdata[7];
              st   <= ST_TX;
            end else begin
              oe_q <= 1'b0;
              ph   <= (ph == PH_ADDR) ? PH_CMD : PH_DATA;
              st   <= ST_RX;
            end
          end
        end
        ST_TX: begin
          if (scl_rise) cnt <= cnt + 1'b1;
          if (scl_fall) begin
            if (byte_done) begin
              oe_q <= 1'b0;
              st   <= ST_RACK;
            end else begin
              tx   <= {tx[6:0], 1'b0};
              oe_q <= ~tx[6];
            end
          end
        end
        ST_RACK: begin
          if (scl_rise && sda_s) begin
            st <= ST_WAIT;
          end else if (scl_fall) begin
            tx   <= reg_rdata;
            oe_q <= ~reg_rdata[7];
            cnt  <= '0;
            st   <= ST_TX;
          end
        end
        default: ;
      endcase

      if (start_det && st != ST_WAIT) begin
        st   <= ST_RX;
        ph   <= PH_ADDR;
        cnt  <= '0;
        oe_q <= 1'b0;
      end
      if (stop_det) begin
        st   <= ST_IDLE;
        oe_q <= 1'b0;
      end
    end
  end

  assign sda_oe    = oe_q;
  assign reg_wr_en = wr_fire;
  assign reg_wdata = sr;
  assign reg_rd_en = rd_fire;
endmodule

// File: rtl/i2c_regptr_target_chk.sv
module i2c_regptr_target_chk #(
  parameter int PTR_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scl_s,
  input logic             stop_det,
  input logic             sda_oe,
  input logic             reg_wr_en,
  input logic             reg_rd_en,
  input logic [PTR_W-1:0] reg_addr
);
  // R10: the pull-down may begin only while SCL is low
  assert_drive_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> (!scl_s || !sda_oe));

  assert_wr_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |=> !reg_wr_en);

  assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr_en && reg_rd_en));

  assert_ptr_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en || reg_rd_en) |=>
      (reg_addr == {$past(reg_addr[PTR_W-1:1]), ~$past(reg_addr[0])}));

  assert_stop_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);
endmodule

bind i2c_regptr_target i2c_regptr_target_chk #(.PTR_W(PTR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .stop_det(stop_det),
  .sda_oe(sda_oe), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
  .reg_addr(reg_addr)
);

// File: tb/tb_i2c_regptr_target.sv
`timescale 1ns/1ps
module tb_i2c_regptr_target;
  localparam int Q = 10;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [6:0] MY_ADDR = {4'b0100, STRAP};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, reg_wr_en, reg_rd_en;
  logic [2:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic sda_line;

  always #2 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  i2c_regptr_target dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .addr_strap(STRAP), .reg_addr(reg_addr), .reg_wr_en(reg_wr_en),
    .reg_wdata(reg_wdata), .reg_rd_en(reg_rd_en), .reg_rdata(reg_rdata)
  );

  logic [7:0] bank [8];
  assign reg_rdata = bank[reg_addr];
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) bank[i] <= 8'h00;
    end else if (reg_wr_en) begin
      bank[reg_addr] <= reg_wdata;
    end
  end

  logic [7:0] model [8];
  logic [2:0] mptr = 3'd0;
  int nchk = 0, nerr = 0, viol = 0;
  logic prev_oe = 1'b0;

  always @(negedge clk) begin
    if (rst_n && (sda_oe !== prev_oe) && scl_m) viol++;
    prev_oe = sda_oe;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] pair_next(input logic [2:0] p);
    return {p[2:1], ~p[0]};
  endfunction

  task automatic bus_start();
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    bit a1, a2;
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(Q);
      scl_m = 1'b1; tick(2*Q);
      scl_m = 1'b0; tick(Q);
    end
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(1);
    a1 = (sda_line == 1'b0); tick(2*Q - 2);
    a2 = (sda_line == 1'b0); tick(1);
    scl_m = 1'b0; tick(Q);
    acked = a1 && a2;
  endtask

  task automatic recv_byte(input bit nack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; tick(Q);
      scl_m = 1'b1; tick(Q);
      b[i] = sda_line; tick(Q);
      scl_m = 1'b0; tick(Q);
    end
    sda_m = nack; tick(Q);
    scl_m = 1'b1; tick(2*Q);
    scl_m = 1'b0; tick(Q);
    sda_m = 1'b1;
  endtask

  task automatic cmp_bank(input string req);
    bit ok = 1'b1;
    int bad = 0;
    for (int i = 0; i < 8; i++)
      if (bank[i] !== model[i]) begin ok = 1'b0; bad = i; end
    chk(ok, req, bank[bad], model[bad]);
  endtask

  // write: address, command byte, then n data bytes
  task automatic write_txn(input logic [7:0] cmd, input int n, input bit do_stop);
    bit a;
    bus_start();
    send_byte({MY_ADDR, 1'b0}, a); chk(a, "R1 write address ack", a, 1);
    send_byte(cmd, a); chk(a, "R3 command ack", a, 1);
    mptr = cmd[2:0];
    for (int k = 0; k < n; k++) begin
      logic [7:0] d = 8'($urandom);
      send_byte(d, a); chk(a, "R4 data ack", a, 1);
      model[mptr] = d;
      mptr = pair_next(mptr);
    end
    if (do_stop) begin
      bus_stop();
      cmp_bank("R4/R5 register contents");
    end
  endtask

  task automatic read_txn(input int n);
    bit a;
    logic [7:0] d;
    bus_start();
    send_byte({MY_ADDR, 1'b1}, a); chk(a, "R1 read address ack", a, 1);
    for (int k = 0; k < n; k++) begin
      recv_byte(k == n - 1, d);
      chk(d == model[mptr], (k == 0) ? "R6 read byte" : "R7 continued read byte",
          d, model[mptr]);
      mptr = pair_next(mptr);
    end
    bus_stop();
  endtask

  task automatic finish_run();
    chk(viol == 0, "R10 SDA drive changed while SCL high", viol, 0);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    bit a;
    logic [7:0] d;
    void'($urandom(32'd1234));
    for (int i = 0; i < 8; i++) model[i] = 8'h00;
    tick(5);
    // R11: reset state
    chk(sda_oe == 1'b0 && !reg_wr_en && !reg_rd_en, "R11 reset outputs", sda_oe, 0);
    rst_n = 1'b1;
    tick(10);

    // fill registers pairwise, R5 alternation
    for (int p = 0; p < 4; p++) write_txn(8'(2*p), 2, 1'b1);
    chk(sda_oe == 1'b0, "R11 released after STOP", sda_oe, 0);

    // R2: wrong address
    bus_start();
    send_byte({4'b0100, ~STRAP, 1'b0}, a); chk(!a, "R2 no ack on mismatch", a, 0);
    send_byte(8'h02, a); chk(!a, "R2 command ignored", a, 0);
    send_byte(8'h5A, a); chk(!a, "R2 data ignored", a, 0);
    bus_stop();
    cmp_bank("R2 registers unchanged");

    // R9: command write then repeated START into read
    write_txn(8'h05, 0, 1'b0);
    bus_start();
    send_byte({MY_ADDR, 1'b1}, a); chk(a, "R9 read after restart ack", a, 1);
    recv_byte(1'b0, d); chk(d == model[5], "R9 byte from pointed register", d, model[5]);
    recv_byte(1'b1, d); chk(d == model[4], "R5/R7 pair partner", d, model[4]);
    bus_stop();
    mptr = 3'd5;

    // R8: after NACK ignore START until STOP
    bus_start();
    send_byte({MY_ADDR, 1'b1}, a); chk(a, "R8 read ack", a, 1);
    recv_byte(1'b1, d); chk(d == model[mptr], "R8 byte before NACK", d, model[mptr]);
    mptr = pair_next(mptr);
    bus_start();
    send_byte({MY_ADDR, 1'b0}, a); chk(!a, "R8 START ignored after NACK", a, 0);
    send_byte(8'h00, a); chk(!a, "R8 command ignored after NACK", a, 0);
    send_byte(8'hEE, a); chk(!a, "R8 data ignored after NACK", a, 0);
    bus_stop();
    cmp_bank("R8 registers unchanged");
    write_txn(8'h00, 1, 1'b1);

    // random mix
    for (int t = 0; t < 24; t++) begin
      if ($urandom_range(0, 1) == 0) write_txn(8'($urandom), $urandom_range(1, 4), 1'b1);
      else read_txn($urandom_range(1, 4));
    end

    finish_run();
  end
endmodule